// File: doc/BRIEF.md
# Idle-Mode Clock Switching Sequencer

This block sequences the clock handover for a low-power idle mode. On a qualifying sleep request the CPU clock is gated off. The system clock source then moves from the primary oscillator to the internal oscillator multiplexer, and the primary oscillator is shut down. Peripherals are never gated by this block. They keep running from whichever source `src_int_o` selects.

The block also tracks whether the internal output is stable. This tracking depends on the frequency-select value. When a wake-up arrives, the CPU clock restarts from the internal source after a fixed delay. The primary oscillator is restarted at the same moment, and the block waits until that clock reports ready. Readiness means a count of primary oscillator cycles, followed by an optional PLL lock interval. Once the primary clock is ready, the block hands the system clock back to it.

Every delay is a parameter counted in reference clock cycles, except the start-up count, which is counted in primary oscillator cycles. Mode encoding used below: the internal source is selected when `src_int_o` is 1, and the primary source is selected when it is 0.

Top module: `isq_idle_seq`

## Requirements
- R1: After reset the CPU clock is enabled, the primary source is selected, the primary oscillator is enabled, `prim_run_o` is 1 and `int_stable_o` is 0.
- R2: While running on the primary clock, a `sleep_req_i` pulse with `idle_en_i`=1 and `clk_sel_i[1]`=1 (`clk_sel_i[0]` is ignored) behaves as follows. It gates the CPU clock from the next cycle, keeps the primary source selected for ENTRY_CYCLES cycles, and then selects the internal source, disables the primary oscillator and clears `prim_run_o`.
- R3: A `sleep_req_i` pulse with `idle_en_i`=0 or `clk_sel_i[1]`=0 leaves the CPU clock enabled and the primary source selected.
- R4: While `freq_sel_i` is nonzero, `intosc_en_o` is 1. `int_stable_o` sets exactly STAB_CYCLES cycles after `freq_sel_i` becomes nonzero. Changing between nonzero values does not restart that wait.
- R5: When `freq_sel_i` is zero, `intosc_en_o` is 0 and `int_stable_o` is 0 from the next cycle on. It stays 0 through idle entry.
- R6: An `int_stable_o` that was already set before the sleep request stays set through idle entry and idle, with no new wait.
- R7: In idle, a `wake_i` pulse enables the primary oscillator from the next cycle. It keeps the CPU gated for WAKE_CYCLES cycles, and then enables the CPU clock with the internal source still selected.
- R8: A `wake_i` pulse that arrives while entry is still in progress is held. It is serviced as soon as the block reaches idle.
- R9: A `wake_i` pulse while running on the primary clock has no effect.
- R10: In internal-clock run mode the block switches back once OST_TICKS `prim_tick_i` pulses have been counted since the primary oscillator was enabled. If `pll_use_i`=1, it waits a further PLL_CYCLES cycles first. At the switch it selects the primary source, sets `prim_run_o` and clears `int_stable_o`.
- R11: `lfrc_en_o` is 1 whenever `wdt_en_i` or `fscm_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_en_i | input | 1 | Sleep request selects idle instead of full sleep |
| clk_sel_i | input | 2 | System clock select; bit 1 picks the internal source |
| freq_sel_i | input | FREQ_W | Internal frequency select; zero disables the internal output |
| sleep_req_i | input | 1 | Sleep request strobe |
| wake_i | input | 1 | Wake-up event |
| prim_tick_i | input | 1 | One pulse per primary oscillator cycle |
| pll_use_i | input | 1 | Primary path includes a PLL |
| wdt_en_i | input | 1 | Watchdog enabled |
| fscm_en_i | input | 1 | Fail-safe clock monitor enabled |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| src_int_o | output | 1 | System clock source: 1 internal, 0 primary |
| prim_osc_en_o | output | 1 | Primary oscillator enable |
| intosc_en_o | output | 1 | Internal multiplexer output enable |
| lfrc_en_o | output | 1 | Low-frequency internal RC enable |
| int_stable_o | output | 1 | Internal clock stable flag |
| prim_run_o | output | 1 | Primary clock running flag |

## Verification
The bound assertions are checked on every cycle and cover the following:
- At entry, the source change coincides with primary shutdown and cleared running status.
- The CPU clock only restarts on the internal source.
- The primary oscillator restarts while the CPU is still held.
- The hand-back sets running status and clears stability.
- The stable flag can only rise after the internal output has been enabled.
- A non-qualifying sleep request leaves the CPU clock running.

The exact lengths of the entry, wake and stabilization windows, the PLL wait, and the servicing of a wake latched during entry can only be shown by the bench. It drives those scenarios against a cycle-level reference model.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [2:0] {
    M_PRI   = 3'd0,
    M_ENTER = 3'd1,
    M_IDLE  = 3'd2,
    M_WAKE  = 3'd3,
    M_RCRUN = 3'd4
  } isq_mode_e;
endpackage

// File: rtl/isq_rst_sync.sv
module isq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/isq_timer.sv
// Saturating interval counter: fin_o marks the LIMIT-th running cycle.
module isq_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic fin_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                        cnt_d = '0;
    else if (run_i && cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign fin_o = run_i & ~clr_i & (cnt_q == LAST);
endmodule

// File: rtl/isq_osc_ready.sv
// Primary readiness: start-up tick count, then optional PLL lock wait.
module isq_osc_ready #(
  parameter int unsigned OST_TICKS  = 1024,
  parameter int unsigned PLL_CYCLES = 16000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic tick_i,
  input  logic pll_use_i,
  output logic ready_o
);
  logic ost_ok_q, ost_ok_d, pll_ok_q, pll_ok_d;
  logic ost_fin, pll_fin;

  isq_timer #(.LIMIT(OST_TICKS)) u_ost (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (~osc_en_i),
    .run_i (tick_i & osc_en_i & ~ost_ok_q),
    .fin_o (ost_fin)
  );

  isq_timer #(.LIMIT(PLL_CYCLES)) u_pll (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (~osc_en_i),
    .run_i (ost_ok_q & pll_use_i & ~pll_ok_q),
    .fin_o (pll_fin)
  );

  always_comb begin
    ost_ok_d = ost_ok_q;
    pll_ok_d = pll_ok_q;
    if (!osc_en_i) begin
      ost_ok_d = 1'b0;
      pll_ok_d = 1'b0;
    end else begin
      if (ost_fin) ost_ok_d = 1'b1;
      if (pll_fin) pll_ok_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ost_ok_q <= 1'b0;
      pll_ok_q <= 1'b0;
    end else begin
      ost_ok_q <= ost_ok_d;
      pll_ok_q <= pll_ok_d;
    end
  end

  assign ready_o = ost_ok_q & (~pll_use_i | pll_ok_q);
endmodule

// File: rtl/isq_stab_flag.sv
// Internal-output stable flag with its settling window.
module isq_stab_flag #(
  parameter int unsigned STAB_CYCLES = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freq_on_i,
  input  logic drop_i,
  output logic stable_o
);
  logic stable_q, stable_d, fin;

  isq_timer #(.LIMIT(STAB_CYCLES)) u_stab (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (~freq_on_i | drop_i),
    .run_i (freq_on_i & ~stable_q),
    .fin_o (fin)
  );

  always_comb begin
    stable_d = stable_q;
    if (!freq_on_i || drop_i) stable_d = 1'b0;
    else if (fin)             stable_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stable_q <= 1'b0;
    else         stable_q <= stable_d;
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/isq_idle_seq.sv
module isq_idle_seq #(
  parameter int unsigned FREQ_W       = 3,
  parameter int unsigned ENTRY_CYCLES = 2,
  parameter int unsigned WAKE_CYCLES  = 80,
  parameter int unsigned STAB_CYCLES  = 8000,
  parameter int unsigned OST_TICKS    = 1024,
  parameter int unsigned PLL_CYCLES   = 16000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_en_i,
  input  logic [1:0]        clk_sel_i,
  input  logic [FREQ_W-1:0] freq_sel_i,
  input  logic              sleep_req_i,
  input  logic              wake_i,
  input  logic              prim_tick_i,
  input  logic              pll_use_i,
  input  logic              wdt_en_i,
  input  logic              fscm_en_i,
  output logic              cpu_clk_en_o,
  output logic              src_int_o,
  output logic              prim_osc_en_o,
  output logic              intosc_en_o,
  output logic              lfrc_en_o,
  output logic              int_stable_o,
  output logic              prim_run_o
);
  import isq_pkg::*;

  logic      rst_q;
  isq_mode_e st_q, st_d;
  logic      pend_q, pend_d;
  logic      ent_fin, wake_fin, prim_ready, hand_back, freq_on;
  logic      sel_lo_unused;

  assign sel_lo_unused = clk_sel_i[0];
  assign freq_on       = |freq_sel_i;

  isq_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_q));

  isq_timer #(.LIMIT(ENTRY_CYCLES)) u_ent (
    .clk_i(clk_i), .rst_ni(rst_q),
    .clr_i(st_q != M_ENTER), .run_i(st_q == M_ENTER), .fin_o(ent_fin)
  );

  isq_timer #(.LIMIT(WAKE_CYCLES)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_q),
    .clr_i(st_q != M_WAKE), .run_i(st_q == M_WAKE), .fin_o(wake_fin)
  );

  isq_osc_ready #(.OST_TICKS(OST_TICKS), .PLL_CYCLES(PLL_CYCLES)) u_rdy (
    .clk_i(clk_i), .rst_ni(rst_q),
    .osc_en_i(prim_osc_en_o), .tick_i(prim_tick_i),
    .pll_use_i(pll_use_i), .ready_o(prim_ready)
  );

  assign hand_back = (st_q == M_RCRUN) && prim_ready;

  isq_stab_flag #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk_i(clk_i), .rst_ni(rst_q),
    .freq_on_i(freq_on), .drop_i(hand_back), .stable_o(int_stable_o)
  );

  // next-state
  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    unique case (st_q)
      M_PRI:   if (sleep_req_i && idle_en_i && clk_sel_i[1]) st_d = M_ENTER;
      M_ENTER: begin
        if (wake_i)  pend_d = 1'b1;
        if (ent_fin) st_d   = M_IDLE;
      end
      M_IDLE:  if (wake_i || pend_q) begin
        st_d   = M_WAKE;
        pend_d = 1'b0;
      end
      M_WAKE:  if (wake_fin) st_d = M_RCRUN;
      M_RCRUN: if (hand_back) st_d = M_PRI;
      default: st_d = M_PRI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= M_PRI;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  // output decode
  always_comb begin
    cpu_clk_en_o  = 1'b0;
    src_int_o     = 1'b1;
    prim_osc_en_o = 1'b1;
    prim_run_o    = 1'b0;
    unique case (st_q)
      M_PRI:   begin cpu_clk_en_o = 1'b1; src_int_o = 1'b0; prim_run_o = 1'b1; end
      M_ENTER: begin src_int_o = 1'b0; prim_run_o = 1'b1; end
      M_IDLE:  prim_osc_en_o = 1'b0;
      M_WAKE:  ;
      M_RCRUN: cpu_clk_en_o = 1'b1;
      default: ;
    endcase
  end

  assign intosc_en_o = freq_on;
  assign lfrc_en_o   = wdt_en_i | fscm_en_i;
endmodule

// File: rtl/isq_idle_seq_chk.sv
module isq_idle_seq_chk #(
  parameter int unsigned FREQ_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              idle_en_i,
  input logic [1:0]        clk_sel_i,
  input logic [FREQ_W-1:0] freq_sel_i,
  input logic              sleep_req_i,
  input logic              cpu_clk_en_o,
  input logic              src_int_o,
  input logic              prim_osc_en_o,
  input logic              intosc_en_o,
  input logic              int_stable_o,
  input logic              prim_run_o
);
  assert_entry_shutdown_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(src_int_o) |-> (!prim_osc_en_o && !prim_run_o && !cpu_clk_en_o));

  assert_sleep_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && !src_int_o && sleep_req_i && !(idle_en_i && clk_sel_i[1]))
      |=> cpu_clk_en_o);

  assert_stable_needs_osc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_stable_o) |-> (intosc_en_o && $past(intosc_en_o)));

  assert_zero_freq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_sel_i == '0 && $past(freq_sel_i == '0)) |-> (!int_stable_o && !intosc_en_o));

  assert_cpu_restart_int_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> src_int_o);

  assert_osc_restart_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prim_osc_en_o) |-> (src_int_o && !cpu_clk_en_o));

  assert_hand_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(src_int_o) |-> (prim_run_o && !int_stable_o && $past(cpu_clk_en_o)));
endmodule

bind isq_idle_seq isq_idle_seq_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .idle_en_i(idle_en_i), .clk_sel_i(clk_sel_i),
  .freq_sel_i(freq_sel_i), .sleep_req_i(sleep_req_i), .cpu_clk_en_o(cpu_clk_en_o),
  .src_int_o(src_int_o), .prim_osc_en_o(prim_osc_en_o), .intosc_en_o(intosc_en_o),
  .int_stable_o(int_stable_o), .prim_run_o(prim_run_o)
);

// File: tb/isq_idle_seq_test.sv
`timescale 1ns/1ps
module isq_idle_seq_test;
  localparam int E = 2, W = 5, S = 20, O = 8, P = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic idle_en, sleep, wake, tick, pll_use, wdt, fscm;
  logic [1:0] sel;
  logic [2:0] freq;
  logic cpu, src, posc, iosc, lfrc, stable, prun;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  isq_idle_seq #(.FREQ_W(3), .ENTRY_CYCLES(E), .WAKE_CYCLES(W), .STAB_CYCLES(S),
                 .OST_TICKS(O), .PLL_CYCLES(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .idle_en_i(idle_en), .clk_sel_i(sel),
    .freq_sel_i(freq), .sleep_req_i(sleep), .wake_i(wake), .prim_tick_i(tick),
    .pll_use_i(pll_use), .wdt_en_i(wdt), .fscm_en_i(fscm),
    .cpu_clk_en_o(cpu), .src_int_o(src), .prim_osc_en_o(posc), .intosc_en_o(iosc),
    .lfrc_en_o(lfrc), .int_stable_o(stable), .prim_run_o(prun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: mode 0 primary run, 1 entering, 2 idle, 3 wake delay, 4 internal run
  int m_mode, m_cnt, m_sync, m_scnt, m_ticks, m_pllc;
  bit m_pend, m_stable, m_ostok, m_pllok;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_mode = 0; m_cnt = 0; m_pend = 0; m_scnt = 0; m_stable = 0;
      m_ticks = 0; m_ostok = 0; m_pllc = 0; m_pllok = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit osc_on, ready, back, n_stable, n_ostok, n_pllok, n_pend;
      int n_scnt, n_ticks, n_pllc, n_mode, n_cnt;
      osc_on = (m_mode != 2);
      ready  = m_ostok && (!pll_use || m_pllok);
      back   = (m_mode == 4) && ready;
      n_scnt = m_scnt; n_stable = m_stable;
      if (freq == 0 || back) begin n_scnt = 0; n_stable = 0; end
      else if (!m_stable) begin
        if (m_scnt == S-1) n_stable = 1; else n_scnt = m_scnt + 1;
      end
      n_ticks = m_ticks; n_ostok = m_ostok; n_pllc = m_pllc; n_pllok = m_pllok;
      if (!osc_on) begin n_ticks = 0; n_ostok = 0; n_pllc = 0; n_pllok = 0; end
      else begin
        if (tick && !m_ostok) begin
          if (m_ticks == O-1) n_ostok = 1; else n_ticks = m_ticks + 1;
        end
        if (m_ostok && pll_use && !m_pllok) begin
          if (m_pllc == P-1) n_pllok = 1; else n_pllc = m_pllc + 1;
        end
      end
      n_mode = m_mode; n_cnt = m_cnt; n_pend = m_pend;
      case (m_mode)
        0: if (sleep && idle_en && sel[1]) begin n_mode = 1; n_cnt = 0; end
        1: begin
             if (wake) n_pend = 1;
             if (m_cnt == E-1) n_mode = 2; else n_cnt = m_cnt + 1;
           end
        2: if (wake || m_pend) begin n_mode = 3; n_cnt = 0; n_pend = 0; end
        3: if (m_cnt == W-1) n_mode = 4; else n_cnt = m_cnt + 1;
        default: if (ready) n_mode = 0;
      endcase
      m_mode = n_mode; m_cnt = n_cnt; m_pend = n_pend; m_scnt = n_scnt;
      m_stable = n_stable; m_ticks = n_ticks; m_ostok = n_ostok;
      m_pllc = n_pllc; m_pllok = n_pllok;
    end
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R7",  "cpu_clk_en", cpu,  (m_mode == 0 || m_mode == 4));
      chk("R2",  "src_int",    src,  (m_mode >= 2));
      chk("R7",  "prim_osc_en", posc, (m_mode != 2));
      chk("R10", "prim_run",   prun, (m_mode <= 1));
      chk("R5",  "intosc_en",  iosc, (freq != 0));
      chk("R11", "lfrc_en",    lfrc, (wdt | fscm));
      chk("R4",  "int_stable", stable, m_stable);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1);
    end
    tick = 1'b0;
  endtask

  task automatic sleep_pulse(input logic ie, input logic [1:0] s);
    idle_en = ie; sel = s; sleep = 1'b1; cyc(1); sleep = 1'b0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; idle_en = 0; sleep = 0; wake = 0; tick = 0; pll_use = 0;
    wdt = 0; fscm = 0; sel = 2'b00; freq = 3'd0;
    cyc(3); rst_n = 1; cyc(4);
    chk("R1", "cpu", cpu, 1); chk("R1", "src", src, 0);
    chk("R1", "prun", prun, 1); chk("R1", "posc", posc, 1); chk("R1", "stable", stable, 0);

    wdt = 1; cyc(1); chk("R11", "lfrc wdt", lfrc, 1);
    wdt = 0; fscm = 1; cyc(1); chk("R11", "lfrc fscm", lfrc, 1);
    fscm = 0; cyc(1); chk("R11", "lfrc off", lfrc, 0);

    freq = 3'd3; cyc(S-1); chk("R4", "stable early", stable, 0);
    cyc(1); chk("R4", "stable set", stable, 1); chk("R4", "intosc", iosc, 1);
    freq = 3'd6; cyc(2); chk("R4", "stable kept on reselect", stable, 1);

    sleep_pulse(1'b0, 2'b10); chk("R3", "cpu idle_en=0", cpu, 1); chk("R3", "src", src, 0);
    sleep_pulse(1'b1, 2'b01); chk("R3", "cpu sel=01", cpu, 1);
    cyc(2); chk("R3", "cpu later", cpu, 1);

    sleep_pulse(1'b1, 2'b10);
    chk("R2", "cpu gated", cpu, 0); chk("R2", "src still primary", src, 0);
    chk("R2", "prun during entry", prun, 1);
    cyc(E);
    chk("R2", "src internal", src, 1); chk("R2", "posc off", posc, 0);
    chk("R2", "prun cleared", prun, 0); chk("R6", "stable kept", stable, 1);
    cyc(10); chk("R6", "stable in idle", stable, 1); chk("R7", "cpu idle", cpu, 0);

    wake = 1; cyc(1); wake = 0;
    chk("R7", "posc restarted", posc, 1); chk("R7", "cpu held", cpu, 0);
    cyc(W-1); chk("R7", "cpu still held", cpu, 0);
    cyc(1); chk("R7", "cpu restarted", cpu, 1); chk("R7", "src internal", src, 1);

    ticks(O); chk("R10", "no early switch", src, 1);
    cyc(1); chk("R10", "src primary", src, 0); chk("R10", "prun", prun, 1);
    chk("R10", "stable cleared", stable, 0);

    freq = 3'd0; cyc(1); chk("R5", "stable", stable, 0); chk("R5", "intosc", iosc, 0);
    sleep_pulse(1'b1, 2'b11); cyc(E+3);
    chk("R5", "idle src", src, 1); chk("R5", "stable in idle", stable, 0);

    wake = 1; cyc(1); wake = 0; cyc(W); chk("R7", "cpu on", cpu, 1);
    pll_use = 1; ticks(O); chk("R10", "pll wait start", src, 1);
    cyc(P); chk("R10", "pll wait end", src, 1);
    cyc(1); chk("R10", "pll switch", src, 0);
    pll_use = 0;

    freq = 3'd5;
    sleep_pulse(1'b1, 2'b10);
    wake = 1; cyc(1); wake = 0;
    chk("R8", "still entering", src, 0);
    cyc(1); chk("R8", "reached idle", src, 1); chk("R8", "posc off", posc, 0);
    cyc(1); chk("R8", "wake serviced", posc, 1);
    cyc(W); chk("R8", "cpu on", cpu, 1);

    ticks(O); cyc(2); chk("R10", "back on primary", src, 0);
    wake = 1; cyc(1); wake = 0;
    chk("R9", "cpu", cpu, 1); chk("R9", "src", src, 0); chk("R9", "posc", posc, 1);
    cyc(3); chk("R9", "cpu later", cpu, 1); chk("R9", "src later", src, 0);

    finish_run();
  end
endmodule